// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a single-word system request port and a pseudo-SRAM that is run in its asynchronous, SRAM-style bus mode. The system side offers one read or write at a time, with a 16-bit word, two byte-lane enables, a ready flag and a one-cycle completion pulse. On the memory side it drives the active-low chip, output, write and byte-lane strobes, the address-valid strobe, the unused memory clock and the address. The data bus is split into an output word, an output-enable and a sampled input word, so the pad ring can build the tri-state buffer.

After reset the controller keeps the memory deselected for the power-up interval, which it derives from a clock-frequency parameter and a time parameter. After that it runs each access as a fixed sequence of clock cycles. The sequence has an address phase, then an active phase whose length is the read access time or the write pulse width, then a data-hold cycle for writes, then a recovery gap with chip enable high. The write pulse is shortened when needed so that no chip-enable assertion outlasts the maximum set by a parameter, which leaves the memory its hidden refresh slot. The address-valid strobe is either a one-cycle latch pulse or is held low for the whole access, chosen by a parameter. The device's wait output is ignored.

Top module: `psram_async_ctrl`

## Requirements
- R1: From reset until ceil(CLK_MHZ*PWRUP_NS/1000) clock cycles have passed, mem_ce_n stays 1 and ready stays 0, and requests are not taken. With the defaults this is 15000 cycles.
- R2: A read holds mem_ce_n=0 and mem_we_n=1. mem_oe_n=0 is asserted only in that state, and the lane strobes (mem_lb_n for bits 7:0, mem_ub_n for bits 15:8) are 0 only for lanes whose req_be bit is 1 (bit 0 selects the low byte).
- R3: Read data is sampled at the end of T_ACC consecutive cycles with mem_oe_n=0, never earlier. A read keeps mem_ce_n low for 1+T_ACC cycles.
- R4: A write holds mem_ce_n=0 and mem_oe_n=1 for the whole time mem_we_n=0.
- R5: After mem_we_n returns high, mem_dq_oe stays 1 and mem_dq_out stays unchanged for one more cycle with chip enable still low.
- R6: With ADV_PULSE=1, mem_adv_n is low for exactly one cycle per access, the first. With ADV_PULSE=0, mem_adv_n is low for every cycle that mem_ce_n is low.
- R7: mem_clk is 0 at all times, including during reset.
- R8: mem_wait has no effect on any output or on the returned data.
- R9: The write pulse lasts min(T_WE, T_CEM-2) cycles and no chip-enable assertion is longer than T_CEM cycles. With the defaults the write pulse is 6 cycles and the write assertion is 8 cycles.
- R10: Between two accesses mem_ce_n stays high for at least T_REC cycles.
- R11: mem_dq_oe is 1 only while mem_oe_n=1 and mem_ce_n=0 during a write, and it is 0 during reads, recovery and idle.
- R12: Each access ends with done high for exactly one cycle. For a read, rdata carries the sampled word in that cycle, with the byte lanes whose req_be bit is 0 forced to zero.
- R13: ready is 1 only while idle after power-up. It goes to 0 in the cycle after a request is taken and stays 0 until done has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when ready is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte lane strobe, active low |
| mem_ub_n | output | 1 | High byte lane strobe, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_clk | output | 1 | Memory clock, held low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | 16 | Sampled data bus |
| mem_wait | input | 1 | Device wait output, ignored |

## Verification
A wrong sequencer state shows up at once at the memory strobes. Output enable and write enable would overlap, chip-enable or write pulses would come out one cycle too long or too short, or the data bus would be driven while output enable is low. The bench measures every pulse width on each access, so such errors appear within the access that causes them. A wrong sample point in the read path appears in the same access as a corrupt rdata word, because the memory model returns garbage until the full access time has passed. A wrong power-up counter shows as ready rising at the wrong cycle, or as chip enable going low during the power-up window.

// File: rtl/psram_async_pkg.sv
package psram_async_pkg;

  localparam int unsigned DW = 16;
  localparam int unsigned NB = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_ACT  = 3'd2,
    ST_HOLD = 3'd3,
    ST_REC  = 3'd4
  } acc_state_e;

  // cycles needed to cover wait_ns at clk_mhz, rounded up
  function automatic int unsigned pwrup_cycles(int unsigned clk_mhz, int unsigned wait_ns);
    return (clk_mhz * wait_ns + 999) / 1000;
  endfunction

  // write pulse shortened so that address cycle + pulse + hold cycle fits the cap
  function automatic int unsigned we_pulse_cycles(int unsigned want, int unsigned cem_max);
    if (want + 2 > cem_max) return cem_max - 2;
    return want;
  endfunction

  // zero the byte lanes that were not requested
  function automatic logic [DW-1:0] lane_mask(logic [DW-1:0] d, logic [NB-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

endpackage

// File: rtl/psram_pwrup_timer.sv
module psram_pwrup_timer #(
  parameter int unsigned CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (cnt_q == CW'(CYCLES - 1)) init_done <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: once the window is over it never reopens
  a_r1_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

// File: rtl/psram_access_fsm.sv
module psram_access_fsm
  import psram_async_pkg::*;
#(
  parameter int unsigned T_ACC     = 6,
  parameter int unsigned T_WE_EFF  = 6,
  parameter int unsigned T_REC     = 2,
  parameter int unsigned T_CEM     = 8,
  parameter bit          ADV_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done,
  input  logic req,
  input  logic req_wr,
  output logic ready,
  output logic accept,
  output logic cap_evt,
  output logic lanes_on,
  output logic dq_drive,
  output logic done,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic adv_n
);
  localparam int unsigned REC_N = (T_REC < 1) ? 1 : T_REC;
  localparam int unsigned CNTW  = $clog2(T_CEM + T_ACC + T_WE_EFF + REC_N + 2);

  acc_state_e      state_q;
  logic [CNTW-1:0] cnt_q;
  logic            wr_q;
  logic            act_last;
  logic            rec_last;

  assign ready    = (state_q == ST_IDLE) && init_done;
  assign accept   = ready && req;
  assign act_last = (state_q == ST_ACT) &&
                    (cnt_q == (wr_q ? CNTW'(T_WE_EFF - 1) : CNTW'(T_ACC - 1)));
  assign rec_last = (state_q == ST_REC) && (cnt_q == CNTW'(REC_N - 1));
  assign cap_evt  = act_last && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (act_last && !wr_q) || (state_q == ST_HOLD);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ADDR;
          wr_q    <= req_wr;
        end
        ST_ADDR: begin
          state_q <= ST_ACT;
          cnt_q   <= '0;
        end
        ST_ACT: begin
          if (act_last) begin
            state_q <= wr_q ? ST_HOLD : ST_REC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          state_q <= ST_REC;
          cnt_q   <= '0;
        end
        ST_REC: begin
          if (rec_last) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ce_n     = !((state_q == ST_ADDR) || (state_q == ST_ACT) || (state_q == ST_HOLD));
  assign oe_n     = !((state_q == ST_ACT) && !wr_q);
  assign we_n     = !((state_q == ST_ACT) && wr_q);
  assign lanes_on = (state_q == ST_ACT);
  assign dq_drive = wr_q && ((state_q == ST_ACT) || (state_q == ST_HOLD));

  generate
    if (ADV_PULSE) begin : g_adv_pulse
      assign adv_n = (state_q != ST_ADDR);
    end else begin : g_adv_hold
      assign adv_n = ce_n;
    end
  endgenerate

  // ---------------- run-length observers for the assertions ----------------
  logic [CNTW-1:0] ce_run_q, we_run_q, oe_run_q, ce_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run_q <= '0;
      we_run_q <= '0;
      oe_run_q <= '0;
      ce_hi_q  <= '0;
    end else begin
      ce_run_q <= ce_n ? '0 : ce_run_q + 1'b1;
      we_run_q <= we_n ? '0 : we_run_q + 1'b1;
      oe_run_q <= oe_n ? '0 : oe_run_q + 1'b1;
      if (!ce_n)                          ce_hi_q <= '0;
      else if (ce_hi_q != CNTW'(REC_N))   ce_hi_q <= ce_hi_q + 1'b1;
    end
  end

  a_r2_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));
  a_r3_sample_after_acc: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (!oe_n && oe_run_q == CNTW'(T_ACC - 1)));
  a_r4_we_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));
  a_r9_we_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (we_run_q < CNTW'(T_WE_EFF)));
  a_r9_ce_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (ce_run_q < CNTW'(T_CEM)));
  a_r10_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> (ce_hi_q >= CNTW'(T_REC)));
  a_r11_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> (oe_n && !ce_n));
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r13_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  generate
    if (ADV_PULSE) begin : g_chk_pulse
      a_r6_adv_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |=> adv_n);
    end else begin : g_chk_hold
      a_r6_adv_whole: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !adv_n);
    end
  endgenerate

endmodule

// File: rtl/psram_data_lane.sv
module psram_data_lane
  import psram_async_pkg::*;
#(
  parameter int unsigned AW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_be,
  input  logic          cap_evt,
  input  logic          lanes_on,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          lb_n,
  output logic          ub_n,
  output logic [DW-1:0] rdata
);
  logic [NB-1:0] be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
      be_q     <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
        be_q     <= req_be;
      end
      if (cap_evt) rdata <= lane_mask(dq_in, be_q);
    end
  end

  assign lb_n = !(lanes_on && be_q[0]);
  assign ub_n = !(lanes_on && be_q[1]);

  // R12: a captured word never carries data in a lane that was not asked for
  a_r12_lanes_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ((be_q[0] || rdata[7:0] == 8'h00) && (be_q[1] || rdata[15:8] == 8'h00)));
  // R2: a lane strobe is only ever low for a requested lane
  a_r2_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_n || !ub_n) |-> ((lb_n || be_q[0]) && (ub_n || be_q[1])));

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_async_pkg::*;
#(
  parameter int unsigned AW        = 23,
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PWRUP_NS  = 150000,
  parameter int unsigned T_ACC     = 6,
  parameter int unsigned T_WE      = 9,
  parameter int unsigned T_REC     = 2,
  parameter int unsigned T_CEM     = 8,
  parameter bit          ADV_PULSE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          ready,
  output logic          done,
  output logic [15:0]   rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic          mem_adv_n,
  output logic          mem_clk,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in,
  input  logic          mem_wait
);
  localparam int unsigned PWR_CYC  = pwrup_cycles(CLK_MHZ, PWRUP_NS);
  localparam int unsigned T_WE_EFF = we_pulse_cycles(T_WE, T_CEM);

  logic init_done;
  logic accept;
  logic cap_evt;
  logic lanes_on;

  psram_pwrup_timer #(.CYCLES(PWR_CYC)) u_pwrup (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done)
  );

  psram_access_fsm #(
    .T_ACC     (T_ACC),
    .T_WE_EFF  (T_WE_EFF),
    .T_REC     (T_REC),
    .T_CEM     (T_CEM),
    .ADV_PULSE (ADV_PULSE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .req       (req),
    .req_wr    (req_wr),
    .ready     (ready),
    .accept    (accept),
    .cap_evt   (cap_evt),
    .lanes_on  (lanes_on),
    .dq_drive  (mem_dq_oe),
    .done      (done),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .adv_n     (mem_adv_n)
  );

  psram_data_lane #(.AW(AW)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .cap_evt   (cap_evt),
    .lanes_on  (lanes_on),
    .dq_in     (mem_dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .lb_n      (mem_lb_n),
    .ub_n      (mem_ub_n),
    .rdata     (rdata)
  );

  // asynchronous mode: the memory clock never toggles
  assign mem_clk = 1'b0;

  a_r1_deselect_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (mem_ce_n && !ready));
  a_r5_data_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out)));
  a_r8_wait_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(mem_wait) && ready && !req) |=> mem_ce_n);

endmodule

// File: tb/psram_async_ctrl_tb.sv
module psram_async_ctrl_tb_top;

  localparam int T_ACC_B = 6;
  localparam int T_REC_B = 2;
  localparam int PWR_B   = 150000 / 10;   // 150 us at a 10 ns period
  localparam int WE_B    = 6;             // 9 requested, cap 8 minus address and hold cycles
  localparam int WCE_B   = WE_B + 2;
  localparam int RCE_B   = 1 + T_ACC_B;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic req = 0, req_wr = 0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic ready, done, ce_n, oe_n, we_n, lb_n, ub_n, adv_n, mclk, dq_oe;
  logic [15:0] rdata, dq_out;
  logic [15:0] dq_in = 16'hBAD0;
  logic [22:0] maddr;
  logic mwait = 1'b0;

  psram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .done(done), .rdata(rdata),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_lb_n(lb_n), .mem_ub_n(ub_n),
    .mem_adv_n(adv_n), .mem_clk(mclk), .mem_addr(maddr), .mem_dq_out(dq_out),
    .mem_dq_oe(dq_oe), .mem_dq_in(dq_in), .mem_wait(mwait));

  // second instance: address-valid held for the whole access, short power-up
  logic h_req = 0, h_ready, h_done, h_ce_n, h_oe_n, h_we_n, h_lb_n, h_ub_n, h_adv_n, h_clk, h_oe;
  logic [15:0] h_rdata, h_dq_out;
  logic [22:0] h_addr;
  psram_async_ctrl #(.PWRUP_NS(500), .ADV_PULSE(1'b0)) dut_h (
    .clk(clk), .rst_n(rst_n), .req(h_req), .req_wr(1'b0), .req_addr(23'd5),
    .req_wdata(16'h0), .req_be(2'b11), .ready(h_ready), .done(h_done), .rdata(h_rdata),
    .mem_ce_n(h_ce_n), .mem_oe_n(h_oe_n), .mem_we_n(h_we_n), .mem_lb_n(h_lb_n),
    .mem_ub_n(h_ub_n), .mem_adv_n(h_adv_n), .mem_clk(h_clk), .mem_addr(h_addr),
    .mem_dq_out(h_dq_out), .mem_dq_oe(h_oe), .mem_dq_in(16'h1234), .mem_wait(1'b0));

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- memory model and strobe monitor ----------------
  logic [15:0] mem [16];
  int ce_run = 0, we_run = 0, oe_run = 0, adv_run = 0, hi_run = 0;
  int last_ce_low = 0, last_we_low = 0, last_adv = 0, last_ce_high = 0;
  bit prev_we_low = 0, prev_done = 0;
  bit bad_overlap = 0, bad_contend = 0, bad_hold = 0, bad_ready = 0, bad_done = 0;
  bit bad_clk = 0, bad_init = 0, bad_hadv = 0, bad_lane = 0;
  logic [15:0] we_data;
  bit in_init = 1;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (mclk || h_clk) bad_clk = 1;
    if (rst_n) begin
      if (!ce_n) begin
        if (ce_run == 0) last_ce_high = hi_run;
        ce_run++; hi_run = 0;
        if (!adv_n) adv_run++;
      end else begin
        if (ce_run != 0) begin last_ce_low = ce_run; last_adv = adv_run; end
        ce_run = 0; adv_run = 0; hi_run++;
      end
      if (!we_n) begin
        if (we_run == 0) we_data = dq_out;
        else if (dq_out != we_data) bad_hold = 1;
        we_run++;
        if (!lb_n) mem[maddr[3:0]][7:0]  = dq_out[7:0];
        if (!ub_n) mem[maddr[3:0]][15:8] = dq_out[15:8];
      end else begin
        if (we_run != 0) last_we_low = we_run;
        we_run = 0;
      end
      if (prev_we_low && we_n && (!dq_oe || ce_n || dq_out != we_data)) bad_hold = 1;
      prev_we_low = !we_n;
      if (!oe_n && !we_n) bad_overlap = 1;
      if (dq_oe && !oe_n) bad_contend = 1;
      if (ready && !ce_n) bad_ready = 1;
      if (done && prev_done) bad_done = 1;
      prev_done = done;
      if (in_init && !ce_n) bad_init = 1;
      if (!h_ce_n && h_adv_n) bad_hadv = 1;
      if ((!lb_n || !ub_n) && (oe_n && we_n)) bad_lane = 1;
      oe_run = oe_n ? 0 : oe_run + 1;
      dq_in = (!ce_n && !oe_n && oe_run >= T_ACC_B) ? mem[maddr[3:0]] : 16'hBAD0;
    end
  end

  task automatic do_access(input logic wr, input logic [3:0] a, input logic [15:0] d,
                           input logic [1:0] be, input bit toggle_wait, output logic [15:0] rd);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; req_wr = wr; req_addr = {19'd0, a}; req_wdata = d; req_be = be;
    @(negedge clk);
    req = 0; req_wdata = 16'h0; req_be = 2'b00;
    check(ready == 1'b0, "R13 busy after take", ready, 0);
    while (!done) begin
      @(negedge clk);
      if (toggle_wait) mwait = ~mwait;
    end
    rd = rdata;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [15:0] d;
    logic [1:0]  be;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 4'd1, 16'hA5A5, 2'b11, 16'h0000},
    '{1'b1, 4'd2, 16'h1234, 2'b01, 16'h0000},
    '{1'b0, 4'd1, 16'h0000, 2'b11, 16'hA5A5},
    '{1'b0, 4'd2, 16'h0000, 2'b11, 16'h0034},
    '{1'b0, 4'd1, 16'h0000, 2'b10, 16'hA500},
    '{1'b1, 4'd2, 16'hFF00, 2'b10, 16'h0000},
    '{1'b0, 4'd2, 16'h0000, 2'b11, 16'hFF34},
    '{1'b0, 4'd3, 16'h0000, 2'b01, 16'h0000}
  };

  initial begin
    int waited;
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    check(ce_n == 1'b1 && ready == 1'b0, "R1 reset deselect", {ce_n, ready}, 2'b10);
    check(mclk == 1'b0, "R7 clock low in reset", mclk, 0);
    check(dq_oe == 1'b0 && done == 1'b0, "R11 bus idle in reset", {dq_oe, done}, 0);
    rst_n = 1'b1;
    // a request during power-up must be ignored
    req = 1; req_wr = 1; req_addr = 23'd4; req_wdata = 16'hFFFF; req_be = 2'b11;
    waited = 0;
    @(negedge clk);
    while (!ready) begin waited++; @(negedge clk); end
    req = 0;
    in_init = 0;
    check(waited == PWR_B - 1, "R1 power-up length", waited, PWR_B - 1);
    check(bad_init == 0, "R1 no select during init", bad_init, 0);
    @(negedge clk);
    check(ce_n == 1'b1 && mem[4] == 16'h0000, "R1 early request dropped", mem[4], 0);

    foreach (VECS[i]) begin
      do_access(VECS[i].wr, VECS[i].a, VECS[i].d, VECS[i].be, 1'b0, rd);
      if (VECS[i].wr) begin
        check(last_we_low == WE_B, "R9 write pulse clamp", last_we_low, WE_B);
        check(last_ce_low == WCE_B, "R9 write ce length", last_ce_low, WCE_B);
      end else begin
        check(rd == VECS[i].exp, "R12 read data masked", rd, VECS[i].exp);
        check(last_ce_low == RCE_B, "R3 read ce length", last_ce_low, RCE_B);
      end
      check(last_adv == 1, "R6 adv one-cycle pulse", last_adv, 1);
      check(last_ce_high >= T_REC_B, "R10 recovery gap", last_ce_high, T_REC_B);
    end
    check(mem[1] == 16'hA5A5, "R2 write landed full word", mem[1], 16'hA5A5);
    check(mem[2] == 16'hFF34, "R2 byte lanes honoured", mem[2], 16'hFF34);

    // wait input toggling during a read
    do_access(1'b0, 4'd2, 16'h0, 2'b11, 1'b1, rd);
    check(rd == 16'hFF34, "R8 wait ignored", rd, 16'hFF34);
    check(last_ce_low == RCE_B, "R8 timing unchanged by wait", last_ce_low, RCE_B);

    // back-to-back write then read
    do_access(1'b1, 4'd7, 16'h5AC3, 2'b11, 1'b0, rd);
    do_access(1'b0, 4'd7, 16'h0, 2'b11, 1'b0, rd);
    check(rd == 16'h5AC3, "R3 back-to-back read", rd, 16'h5AC3);
    check(last_ce_high >= T_REC_B, "R10 back-to-back gap", last_ce_high, T_REC_B);

    // held address-valid instance
    @(negedge clk); h_req = 1;
    @(negedge clk); h_req = 0;
    while (!h_done) @(negedge clk);
    check(h_rdata == 16'h1234, "R6 held-adv read", h_rdata, 16'h1234);
    check(bad_hadv == 0, "R6 adv held with ce", bad_hadv, 0);

    check(bad_overlap == 0, "R4 no oe/we overlap", bad_overlap, 0);
    check(bad_hold == 0, "R5 data held past we", bad_hold, 0);
    check(bad_clk == 0, "R7 clock static", bad_clk, 0);
    check(bad_contend == 0, "R11 no bus contention", bad_contend, 0);
    check(bad_done == 0, "R12 done single cycle", bad_done, 0);
    check(bad_ready == 0, "R13 ready only when idle", bad_ready, 0);
    check(bad_lane == 0, "R2 lanes only in active phase", bad_lane, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule